// File: doc/BRIEF.md
# Erasable ROM Control and Identification Model

This block is a clocked, synthesizable behavioural model of the control logic in a byte-wide erasable read-only memory. It is meant to sit in a testbench or an FPGA emulation wherever a real part of that kind would be. Each clock edge samples the pins and decodes them into one operating state. That state decides whether the byte array is read, written or left alone, and whether the data bus is driven at all.

The output-enable pin has two jobs. When the `vpp_hi` flag reports programming voltage on it, the chip-enable level picks between programming and inhibited programming, and the output-enable level is ignored. A separate flag reports the high identification voltage on address bit 9. When that flag is set during a read, the block returns one of two fixed identification bytes. Erase takes one cycle and restores every cell to all ones.

Only the low `STORE_AW` address bits index the array, so higher address bits alias. Every output is registered. Results appear one clock after the pins that produced them.

Top module: `uvrom_ctrl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=0 and no identification request, the next cycle shows `dout_oe`=1. `dout` then holds the byte stored at index `addr[STORE_AW-1:0]`, taken as the array was before that edge.
- R2: With `ce_n`=0, `vpp_hi`=0 and `oe_n`=1, the next cycle shows `dout_oe`=0 and `standby`=0.
- R3: With `ce_n`=1, the next cycle shows `standby`=1 and `dout_oe`=0, whatever the other pins are. With `ce_n`=0, `standby` is 0 the next cycle.
- R4: With `ce_n`=0 and `vpp_hi`=1, the addressed location takes the value old AND `din`, and the next cycle shows `dout_oe`=0.
- R5: With `ce_n`=1 and `vpp_hi`=1, no location changes and the bus stays released.
- R6: An identification request is defined as read conditions plus `a9_hv`=1 with every address bit other than bit 0 and bit 9 at zero. With `addr[0]`=0 it returns 8'h01 the next cycle, and with `addr[0]`=1 it returns 8'h91.
- R7: Each identification byte has odd parity over all 8 bits, and bit 7 is the parity bit.
- R8: With `a9_hv`=1 and any address bit other than bits 0 and 9 set, the block performs a normal array read as in R1.
- R9: After a cycle with `erase_req`=1, every location reads 8'hFF. A program request in that same cycle is discarded.
- R10: After reset, every location reads 8'hFF, `dout_oe`=0 and `standby`=1.
- R11: Programming never turns a 0 bit back into 1. Programming 8'hFF over a stored byte leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Output-enable pin is at programming voltage |
| a9_hv | input | 1 | Address bit 9 is at identification voltage |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data to program |
| erase_req | input | 1 | Single-cycle full erase command |
| dout | output | DATA_W | Read or identification data |
| dout_oe | output | 1 | Data bus drive enable |
| standby | output | 1 | Chip deselected |

## Verification
The hardest case to reach is a collision between a bulk erase and other traffic on the same cycle. This covers a program request that must be dropped and a read whose captured data must still reflect the array before the erase. The stimulus schedules erase on the very edge of a program to a known location and on the edge of a read of a programmed byte, then reads both back. A second hard case is the identification path falling back to an array read. To reach it, bytes are programmed at addresses that differ from an identification address by one bit, and those addresses are then read with `a9_hv` raised.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_INHIBIT = 3'd1,
    ST_PROGRAM = 3'd2,
    ST_BUSOFF  = 3'd3,
    ST_READ    = 3'd4,
    ST_IDENT   = 3'd5
  } op_state_e;
endpackage

// File: rtl/uvrom_decode.sv
module uvrom_decode
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_BIT = 9
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  output op_state_e         state
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_MASK = ~((ONE << ID_BIT) | ONE);

  logic others_zero;
  assign others_zero = ((addr & ID_MASK) == '0);

  always_comb begin
    if (ce_n) begin
      state = vpp_hi ? ST_INHIBIT : ST_STANDBY;
    end else if (vpp_hi) begin
      state = ST_PROGRAM;
    end else if (oe_n) begin
      state = ST_BUSOFF;
    end else if (a9_hv && others_zero) begin
      state = ST_IDENT;
    end else begin
      state = ST_READ;
    end
  end
endmodule

// File: rtl/uvrom_ident.sv
module uvrom_ident #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-2:0] MFR_LO = 7'h01,
  parameter logic [DATA_W-2:0] DEV_LO = 7'h11
) (
  input  logic              pick_dev,
  output logic [DATA_W-1:0] id_byte
);
  logic [DATA_W-2:0] low_bits;
  assign low_bits = pick_dev ? DEV_LO : MFR_LO;
  // top bit makes the total count of ones odd
  assign id_byte  = {~(^low_bits), low_bits};
endmodule

// File: rtl/uvrom_cells.sv
module uvrom_cells #(
  parameter int STORE_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STORE_AW-1:0] idx,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                clr_all,
  output logic [DATA_W-1:0]   rd_q
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live_q, live_d;
  logic [DATA_W-1:0] cur_val, merged, rd_d;

  assign cur_val = live_q[idx] ? mem[idx] : '1;
  assign merged  = cur_val & wr_data;
  assign rd_d    = cur_val;

  always_comb begin
    live_d = live_q;
    if (clr_all) begin
      live_d = '0;
    end else if (wr_en) begin
      live_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) begin
      mem[idx] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= rd_d;
  end
endmodule

// File: rtl/uvrom_ctrl.sv
module uvrom_ctrl
  import uvrom_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                STORE_AW = 10,
  parameter int                ID_BIT   = 9,
  parameter logic [DATA_W-2:0] MFR_LO   = 7'h01,
  parameter logic [DATA_W-2:0] DEV_LO   = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              erase_req,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              standby
);
  op_state_e         state_d, state_q;
  logic [DATA_W-1:0] id_d, id_q;
  logic [DATA_W-1:0] cell_q;
  logic              prog_en;

  uvrom_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_decode (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .addr   (addr),
    .state  (state_d)
  );

  uvrom_ident #(.DATA_W(DATA_W), .MFR_LO(MFR_LO), .DEV_LO(DEV_LO)) u_ident (
    .pick_dev (addr[0]),
    .id_byte  (id_d)
  );

  assign prog_en = (state_d == ST_PROGRAM);

  uvrom_cells #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (addr[STORE_AW-1:0]),
    .wr_en   (prog_en),
    .wr_data (din),
    .clr_all (erase_req),
    .rd_q    (cell_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STANDBY;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (state_d == ST_IDENT) begin
      id_q <= id_d;
    end
  end

  always_comb begin
    dout_oe = (state_q == ST_READ) || (state_q == ST_IDENT);
    standby = (state_q == ST_STANDBY) || (state_q == ST_INHIBIT);
    case (state_q)
      ST_READ:  dout = cell_q;
      ST_IDENT: dout = id_q;
      default:  dout = '0;
    endcase
  end
endmodule

// File: rtl/uvrom_ctrl_chk.sv
module uvrom_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic              erase_req,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              standby
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_MASK = ~((ONE << ID_BIT) | ONE);

  logic rd_req, id_req;
  assign rd_req = !ce_n && !oe_n && !vpp_hi;
  assign id_req = rd_req && a9_hv && ((addr & ID_MASK) == '0);

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (dout_oe && !standby));

  assert_busoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |=> (!dout_oe && !standby));

  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (standby && !dout_oe));

  assert_prog_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |=> !dout_oe);

  assert_mfr_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_req && !addr[0]) |=> (dout == DATA_W'(8'h01)));

  assert_dev_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_req && addr[0]) |=> (dout == DATA_W'(8'h91)));

  assert_id_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_req |=> (^dout == 1'b1));

  assert_erased_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req ##1 (rd_req && !id_req) |=> (dout == '1));
endmodule

bind uvrom_ctrl uvrom_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BIT(ID_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .vpp_hi    (vpp_hi),
  .a9_hv     (a9_hv),
  .addr      (addr),
  .erase_req (erase_req),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .standby   (standby)
);

// File: tb/uvrom_ctrl_test.sv
`timescale 1ns/1ps
module uvrom_ctrl_test;
  localparam int STORE_AW = 10;
  localparam int DEPTH    = 1 << STORE_AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, vpp_hi, a9_hv, erase_req;
  logic [15:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_oe, standby;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [7:0] model [int];

  always #2.5 clk = ~clk;

  uvrom_ctrl #(.STORE_AW(STORE_AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr(addr), .din(din), .erase_req(erase_req),
    .dout(dout), .dout_oe(dout_oe), .standby(standby)
  );

  function automatic logic [7:0] peek(input logic [15:0] a);
    int k = int'(a) % DEPTH;
    return model.exists(k) ? model[k] : 8'hFF;
  endfunction

  task automatic report(input string tag, input logic [7:0] got, input logic [7:0] want);
    misses++;
    $display("FAIL %s: got %02h expected %02h", tag, got, want);
  endtask

  // one vector: drive, let an edge pass, predict, then compare at the falling edge
  task automatic step(input logic c, input logic o, input logic v, input logic h,
                      input logic [15:0] a, input logic [7:0] d, input logic e);
    logic       x_oe, x_sb;
    logic [7:0] x_d;
    string      tag;
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; din = d; erase_req = e;
    @(posedge clk);
    x_d = 8'h00; x_oe = 1'b0; x_sb = c;
    if (c) begin
      tag = v ? "R5" : "R3";
    end else if (v) begin
      tag = "R4";
      if (!e) model[int'(a) % DEPTH] = peek(a) & d;  // R11: only ones become zeros
    end else if (o) begin
      tag = "R2";
    end else if (h && ((a & 16'hFDFE) == 16'h0)) begin
      tag = "R6"; x_oe = 1'b1; x_d = a[0] ? 8'h91 : 8'h01;
    end else begin
      tag = h ? "R8" : "R1"; x_oe = 1'b1; x_d = peek(a);
    end
    if (e) model.delete();  // R9: erase wins over a program on the same edge
    @(negedge clk);
    vectors++;
    if (dout_oe !== x_oe) report({tag, " oe"}, {7'h0, dout_oe}, {7'h0, x_oe});
    else if (standby !== x_sb) report({tag, " standby"}, {7'h0, standby}, {7'h0, x_sb});
    else if (x_oe && dout !== x_d) report(tag, dout, x_d);
    if (tag == "R6") begin
      vectors++;
      if (^dout !== 1'b1) report("R7 parity", dout, x_d);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
    addr = 16'h0; din = 8'h0; erase_req = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;  // R10 reset state
    if (dout_oe !== 1'b0 || standby !== 1'b1)
      report("R10 reset", {6'h0, dout_oe, standby}, 8'h01);
    rst_n = 1'b1;

    step(0, 0, 0, 0, 16'h0005, 8'h00, 0);  // R10 blank reads FF
    step(0, 0, 0, 0, 16'h03FF, 8'h00, 0);
    step(0, 1, 1, 0, 16'h0005, 8'hA5, 0);  // R4 program
    step(0, 0, 0, 0, 16'h0005, 8'h00, 0);
    step(0, 1, 1, 0, 16'h0005, 8'h0F, 0);  // R4 AND-merge
    step(0, 0, 0, 0, 16'h0005, 8'h00, 0);
    step(0, 0, 1, 0, 16'h0005, 8'hFF, 0);  // R11 ones cannot restore
    step(0, 0, 0, 0, 16'h0005, 8'h00, 0);
    step(1, 0, 1, 0, 16'h0006, 8'h00, 0);  // R5 inhibit
    step(0, 0, 0, 0, 16'h0006, 8'h00, 0);
    step(0, 1, 0, 0, 16'h0005, 8'h00, 0);  // R2
    step(1, 0, 0, 0, 16'h0005, 8'h00, 0);  // R3
    step(1, 1, 0, 1, 16'h0000, 8'h00, 0);  // R3
    step(0, 0, 0, 1, 16'h0000, 8'h00, 0);  // R6 maker
    step(0, 0, 0, 1, 16'h0001, 8'h00, 0);  // R6 device
    step(0, 0, 0, 1, 16'h0201, 8'h00, 0);  // R6 with bit 9 also set
    step(0, 1, 1, 0, 16'h0004, 8'h3C, 0);
    step(0, 0, 0, 1, 16'h0004, 8'h00, 0);  // R8 falls back to array
    step(0, 0, 0, 1, 16'h8000, 8'h00, 0);  // R8 upper bit
    step(0, 1, 1, 0, 16'h0410, 8'h5A, 0);  // aliasing write
    step(0, 0, 0, 0, 16'h0010, 8'h00, 0);
    step(0, 0, 0, 0, 16'h0005, 8'h00, 1);  // R9 read on erase edge sees old
    step(0, 0, 0, 0, 16'h0005, 8'h00, 0);  // R9 now FF
    step(0, 1, 1, 0, 16'h0007, 8'h00, 1);  // R9 erase beats program
    step(0, 0, 0, 0, 16'h0007, 8'h00, 0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra;
      logic [3:0]  sel;
      sel = 4'($urandom_range(0, 15));
      ra  = {($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h0, 10'($urandom_range(0, 15))};
      if ($urandom_range(0, 3) == 0) ra[9] = 1'b1;
      step(sel[0] & sel[1], sel[2], (sel == 4'd5) || (sel == 4'd9), sel[3],
           ra, 8'($urandom), ($urandom_range(0, 60) == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule